// File: doc/BRIEF.md
# Segment address translator

This block maps a two-part logical address onto a flat physical address. A logical address has two parts: a segment number and an offset. The segment number selects one entry of a small on-chip segment table. Each entry records where the segment begins in physical memory (its base) and how many addressable units it spans (its limit). A separate count register says how many table entries, starting from entry zero, are currently valid.

A translation request runs two independent bounds checks:
- The segment number must be below the valid-entry count.
- The offset must be below the selected entry's limit.

If both checks pass, the answer is the base plus the offset. If either check fails, the answer is a segmentation fault and no address is produced. The work per request is one comparison against the limit and one addition.

The response is registered and appears one cycle after the request. A configuration port rewrites entries and the count at any time. Software can therefore move a segment to a new base, and later translations follow the move without the requester seeing any change in the logical address.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and `rsp_paddr` are 0. The valid-entry count is 0, so every request made before the count is written faults.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and is 0 otherwise. While `rsp_valid` is 0, `rsp_fault` and `rsp_paddr` are 0.
- R3: A request whose segment number is greater than or equal to the valid-entry count (`len_val` as last written) gets `rsp_fault` = 1.
- R4: A request to a segment inside the count gets `rsp_fault` = 1 when its offset is greater than or equal to that entry's limit. An offset equal to the limit faults, and an entry with limit 0 faults for every offset.
- R5: A request that passes both checks gets `rsp_fault` = 0 and `rsp_paddr` = base + offset. The sum is computed one bit wider than the wider of base and offset, so it never wraps.
- R6: A faulting response drives `rsp_paddr` to 0.
- R7: A write on the configuration port (`cfg_we` or `len_we`) is seen by requests in later cycles. A request presented in the same cycle as the write still sees the old contents.
- R8: With entries (limit, base) = (1000, 1400), (400, 6300), (400, 4300), (1100, 3200), (1000, 4700) in slots 0 to 4 and a count of 5:
  - segment 2, offset 53 translates to 4353;
  - segment 1, offset 400 faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write one table entry this cycle |
| cfg_idx | input | SEG_W | Entry written by `cfg_we` |
| cfg_base | input | BASE_W | New base for the written entry |
| cfg_limit | input | LIM_W | New limit for the written entry |
| len_we | input | 1 | Write the valid-entry count this cycle |
| len_val | input | SEG_W+1 | New valid-entry count |
| req_valid | input | 1 | Translation request present |
| req_seg | input | SEG_W | Segment number of the request |
| req_ofs | input | LIM_W | Offset of the request |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_fault | output | 1 | Segmentation fault for this response |
| rsp_paddr | output | PA_W | Physical address; 0 on a fault |

## Verification
The bench targets the following corner cases and what a wrong design would do in each:

- **Offset equal to the limit.** A design that compares with "greater than" would hand out the address one past the end of the segment.
- **Segment number equal to the count, and a count lowered after use.** A design that checks the wrong bound would translate through stale entries.
- **Base and offset both near their maximum.** A design whose sum is too narrow would wrap to a small address.
- **A relocation written in the same cycle as a request, and then in the cycle before one.** A design with a bypass, or with an extra delay stage, would return the new or the old base at the wrong time.
- **Idle cycles between responses.** A design that leaves stale fault or address values on the outputs is caught here.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int unsigned SEG_W_DFLT  = 3;
  localparam int unsigned BASE_W_DFLT = 16;
  localparam int unsigned LIM_W_DFLT  = 16;

  typedef enum logic [1:0] {
    XL_PASS     = 2'd0,
    XL_BAD_SEG  = 2'd1,
    XL_OVER_LIM = 2'd2
  } xl_verdict_e;

endpackage

// File: rtl/seg_tbl.sv
module seg_tbl #(
  parameter int SEG_W  = 3,
  parameter int BASE_W = 16,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_lim,
  input  logic              len_we,
  input  logic [SEG_W:0]    len_in,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_lim,
  output logic [SEG_W:0]    len_q
);

  localparam int N_ENT = 1 << SEG_W;

  logic [BASE_W-1:0] base_q [N_ENT];
  logic [LIM_W-1:0]  lim_q  [N_ENT];
  logic [N_ENT-1:0]  ent_en;

  // one write enable per slot
  for (genvar g = 0; g < N_ENT; g++) begin : g_dec
    assign ent_en[g] = wr_en && (wr_idx == SEG_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (ent_en[i]) begin
          base_q[i] <= wr_base;
          lim_q[i]  <= wr_lim;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_we) begin
      len_q <= len_in;
    end
  end

  // combinational read: the request sees the table as of the current cycle
  assign rd_base = base_q[rd_idx];
  assign rd_lim  = lim_q[rd_idx];

  // R7: a written slot holds the written pair on the next cycle
  a_r7_entry_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (lim_q[$past(wr_idx)] == $past(wr_lim)));

  // R7: count write lands on the next cycle
  a_r7_len_stored: assert property (@(posedge clk) disable iff (!rst_n)
    len_we |=> len_q == $past(len_in));

endmodule

// File: rtl/seg_chk.sv
module seg_chk
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 3,
  parameter int BASE_W = 16,
  parameter int LIM_W  = 16,
  parameter int PA_W   = 17
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [LIM_W-1:0]  ofs,
  input  logic [SEG_W:0]    len,
  input  logic [BASE_W-1:0] base,
  input  logic [LIM_W-1:0]  lim,
  output xl_verdict_e       verdict,
  output logic [PA_W-1:0]   paddr
);

  logic seg_out;
  logic ofs_out;

  assign seg_out = ({1'b0, seg} >= len);
  assign ofs_out = (ofs >= lim);
  assign paddr   = PA_W'(base) + PA_W'(ofs);

  // the table-length check takes priority over the limit check
  always_comb begin
    if (seg_out)      verdict = XL_BAD_SEG;
    else if (ofs_out) verdict = XL_OVER_LIM;
    else              verdict = XL_PASS;
  end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = SEG_W_DFLT,
  parameter int BASE_W = BASE_W_DFLT,
  parameter int LIM_W  = LIM_W_DFLT,
  localparam int PA_W  = ((BASE_W > LIM_W) ? BASE_W : LIM_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              len_we,
  input  logic [SEG_W:0]    len_val,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [LIM_W-1:0]  req_ofs,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [BASE_W-1:0] sel_base;
  logic [LIM_W-1:0]  sel_lim;
  logic [SEG_W:0]    tbl_len;
  xl_verdict_e       verdict;
  logic [PA_W-1:0]   sum;

  seg_tbl #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_base (cfg_base),
    .wr_lim  (cfg_limit),
    .len_we  (len_we),
    .len_in  (len_val),
    .rd_idx  (req_seg),
    .rd_base (sel_base),
    .rd_lim  (sel_lim),
    .len_q   (tbl_len)
  );

  seg_chk #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .PA_W(PA_W)) u_chk (
    .seg     (req_seg),
    .ofs     (req_ofs),
    .len     (tbl_len),
    .base    (sel_base),
    .lim     (sel_lim),
    .verdict (verdict),
    .paddr   (sum)
  );

  // next-state of the response stage
  logic            vld_d, flt_d;
  logic [PA_W-1:0] pa_d;

  always_comb begin
    vld_d = req_valid;
    flt_d = req_valid && (verdict != XL_PASS);
    pa_d  = (req_valid && (verdict == XL_PASS)) ? sum : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= vld_d;
      rsp_fault <= flt_d;
      rsp_paddr <= pa_d;
    end
  end

  // R2: response strobe tracks the request one cycle later
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> !rsp_valid && !rsp_fault);

  // R3: segment number at or beyond the count faults
  a_r3_seg_fault: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && ({1'b0, req_seg} >= tbl_len)) |=> rsp_fault);

  // R4: offset at or beyond the limit faults
  a_r4_lim_fault: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && ({1'b0, req_seg} < tbl_len) && (req_ofs >= sel_lim)) |=> rsp_fault);

  // R5: in-bounds request never faults
  a_r5_in_bounds: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && ({1'b0, req_seg} < tbl_len) && (req_ofs < sel_lim)) |=> !rsp_fault);

  // R6: no address leaks out with a fault
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_fault |-> (rsp_paddr == '0) && rsp_valid);

endmodule

// File: tb/sim_seg_xlate_top.sv
`timescale 1ns/1ps
module sim_seg_xlate_top;

  localparam int SEG_W  = 3;
  localparam int BASE_W = 16;
  localparam int LIM_W  = 16;
  localparam int PA_W   = 17;
  localparam int N_ENT  = 1 << SEG_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [SEG_W-1:0]  cfg_idx;
  logic [BASE_W-1:0] cfg_base;
  logic [LIM_W-1:0]  cfg_limit;
  logic              len_we;
  logic [SEG_W:0]    len_val;
  logic              req_valid;
  logic [SEG_W-1:0]  req_seg;
  logic [LIM_W-1:0]  req_ofs;
  logic              rsp_valid;
  logic              rsp_fault;
  logic [PA_W-1:0]   rsp_paddr;

  always #2.5 clk = ~clk;

  seg_xlate_top #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .len_we(len_we), .len_val(len_val),
    .req_valid(req_valid), .req_seg(req_seg), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  // reference model of the table
  logic [BASE_W-1:0] m_base [N_ENT];
  logic [LIM_W-1:0]  m_lim  [N_ENT];
  int                m_len;

  // scoreboard
  bit              q_flt [$];
  logic [PA_W-1:0] q_pa  [$];
  string           q_tag [$];

  task automatic chk(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // one cycle of stimulus; the expected result uses the table before this cycle's writes
  task automatic cyc(input bit cw, input int idx, input int base, input int lim,
                     input bit lw, input int len,
                     input bit rv, input int seg, input int ofs, input string tag);
    @(negedge clk);
    cfg_we    = cw;
    cfg_idx   = SEG_W'(idx);
    cfg_base  = BASE_W'(base);
    cfg_limit = LIM_W'(lim);
    len_we    = lw;
    len_val   = (SEG_W+1)'(len);
    req_valid = rv;
    req_seg   = SEG_W'(seg);
    req_ofs   = LIM_W'(ofs);
    if (rv) begin
      if (seg >= m_len || ofs >= int'(m_lim[seg])) begin
        q_flt.push_back(1'b1);
        q_pa.push_back('0);
      end else begin
        q_flt.push_back(1'b0);
        q_pa.push_back(PA_W'(m_base[seg]) + PA_W'(ofs));
      end
      q_tag.push_back(tag);
    end
    if (cw) begin
      m_base[idx] = BASE_W'(base);
      m_lim[idx]  = LIM_W'(lim);
    end
    if (lw) m_len = len;
  endtask

  task automatic rq(input int seg, input int ofs, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, seg, ofs, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_en) begin
        if (q_flt.size() != 0) begin
          bit              ef;
          logic [PA_W-1:0] ep;
          string           t;
          ef = q_flt.pop_front();
          ep = q_pa.pop_front();
          t  = q_tag.pop_front();
          chk(rsp_valid && rsp_fault == ef && rsp_paddr == ep, t,
              $sformatf("valid=%0b fault=%0b paddr=%0d expected valid=1 fault=%0b paddr=%0d",
                        rsp_valid, rsp_fault, rsp_paddr, ef, ep));
        end else begin
          // R2: idle outputs
          chk(!rsp_valid && !rsp_fault && rsp_paddr == '0, "R2",
              $sformatf("valid=%0b fault=%0b paddr=%0d expected 0/0/0",
                        rsp_valid, rsp_fault, rsp_paddr));
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_ENT; i++) begin
      m_base[i] = '0;
      m_lim[i]  = '0;
    end
    m_len     = 0;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_idx   = '0;
    cfg_base  = '0;
    cfg_limit = '0;
    len_we    = 1'b0;
    len_val   = '0;
    req_valid = 1'b0;
    req_seg   = '0;
    req_ofs   = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state of outputs
    chk(!rsp_valid && !rsp_fault && rsp_paddr == '0, "R1",
        $sformatf("valid=%0b fault=%0b paddr=%0d expected 0/0/0", rsp_valid, rsp_fault, rsp_paddr));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R1 / R3: count is 0 after reset, so everything faults
    rq(0, 0, "R1");
    idle(1);

    // R8 table
    cyc(1, 0, 1400, 1000, 0, 0, 0, 0, 0, "");
    cyc(1, 1, 6300, 400,  0, 0, 0, 0, 0, "");
    cyc(1, 2, 4300, 400,  0, 0, 0, 0, 0, "");
    cyc(1, 3, 3200, 1100, 0, 0, 0, 0, 0, "");
    cyc(1, 4, 4700, 1000, 1, 5, 0, 0, 0, "");
    rq(2, 53,  "R8");
    rq(1, 400, "R8");
    idle(2);
    // R4: limit boundary
    rq(1, 399,  "R4");
    rq(3, 1100, "R4");
    rq(0, 999,  "R5");
    rq(4, 0,    "R5");
    // R3: count boundary
    rq(5, 0, "R3");
    rq(7, 3, "R3");
    idle(1);
    // R4: limit zero (slot 6 never written, inside count after raise)
    cyc(0, 0, 0, 0, 1, 8, 0, 0, 0, "");
    rq(6, 0, "R4");
    // R5: widest sum
    cyc(1, 5, 65535, 65535, 0, 0, 0, 0, 0, "");
    rq(5, 65534, "R5");
    // R7: relocation seen on the next request
    cyc(1, 2, 9000, 400, 0, 0, 0, 0, 0, "");
    rq(2, 53, "R7");
    // R7: write in the same cycle as a request - old base used
    cyc(1, 2, 100, 400, 0, 0, 1, 2, 53, "R7");
    rq(2, 53, "R7");
    // R3: lower the count, old entries now fault
    cyc(0, 0, 0, 0, 1, 2, 0, 0, 0, "");
    rq(2, 0, "R3");
    rq(1, 10, "R5");
    // R6: fault then pass back-to-back
    rq(1, 400, "R6");
    rq(0, 0,   "R6");
    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule